// File: doc/BRIEF.md
# Operating-System Tick Timer with Four Match Channels

The block is a memory-mapped timer for an operating system's scheduler and watchdog. A 32-bit counter moves up by one on every clock in which `tick_en` is high, wraps past all-ones to zero, and software may load it at any time. Four match registers are compared against the counter. When an increment brings the counter onto a channel's match value, that channel records a sticky status bit and raises its own interrupt line. This happens only if its interrupt-enable bit is set. Software drops the line by writing a one to the status bit.

Channel 3 also serves as a one-shot watchdog. A small state machine follows the watchdog-enable register. In `WD_OFF`, a write with bit 0 set moves it to `WD_ARMED`. In `WD_ARMED`, a channel-3 match moves it to `WD_BITE` and clears the register; a write with bit 0 clear returns it to `WD_OFF`. `WD_BITE` lasts one cycle and drives `rst_req`. From there it goes to `WD_ARMED` if a write with bit 0 set lands in that cycle, and otherwise to `WD_OFF`. The watchdog does not depend on the channel's interrupt-enable bit.

Registers sit behind a simple bus: byte address, write data, write strobe, read strobe and registered read data with an error flag.

Top module: `os_tick_timer`

## Requirements
- R1: After reset the counter, all match registers, interrupt enable, status and watchdog enable read 0, every `irq` bit is low and `rst_req` is low.
- R2: The counter advances by exactly one on each clock with `tick_en` high and holds otherwise; from 0xFFFFFFFF it wraps to 0.
- R3: A counter write loads the written value, overrides a tick in the same cycle, and counting resumes from that value.
- R4: When an increment makes the counter equal to match n and interrupt-enable bit n is 1, status bit n and `irq[n]` are high in the same cycle in which the counter holds that value, and they stay high.
- R5: A match on a channel whose interrupt-enable bit is 0 leaves its status bit and `irq` line at 0.
- R6: A counter write that lands on a match value raises no event, and neither does a counter resting on that value while no tick arrives.
- R7: A status write clears exactly the bits written as 1 that are set; bits written as 0 stay; a cleared channel's `irq` goes low the next cycle.
- R8: The interrupt-enable register keeps only bits 11:0 of a write; bits 31:12 read as 0. Bit n (n = 0..3) enables channel n.
- R9: A channel-3 match while watchdog-enable bit 0 is 1 drives `rst_req` high for exactly one cycle, in the cycle in which the counter holds the match value, whatever interrupt-enable bit 3 holds, and leaves the watchdog-enable register reading 0.
- R10: While watchdog-enable bit 0 is 0, a channel-3 match produces no `rst_req`; the register keeps its written value.
- R11: A match value below the current count fires only after the counter wraps through zero.
- R12: `rd_data` and `rd_err` reflect a read one cycle after `rd_en`. A read of an unmapped address returns 0 with `rd_err` = 1. A mapped read has `rd_err` = 0. A write to an unmapped address changes nothing.
- R13: Byte offsets: match 0..3 at 0x00, 0x04, 0x08, 0x0C; counter 0x10; status 0x14 (bit n = channel n); watchdog enable 0x18; interrupt enable 0x1C. Any other address, including unaligned ones, is unmapped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Counter advance enable |
| addr | input | 8 | Register byte address |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data, valid the cycle after `rd_en` |
| rd_err | output | 1 | Unmapped-read flag, with `rd_data` |
| irq | output | 4 | Per-channel interrupt lines |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The bench builds the block with its default parameters: a 32-bit counter, four channels, a 12-bit enable field and an 8-bit address. The counter can be loaded directly, so the wrap from all-ones to zero and matches just beyond it take only a few ticks to reach. With the same loading, each channel's match value can be approached from one below or placed exactly on the counter. That brings the event timing, the load-equals-match case and the full `WD_OFF`/`WD_ARMED`/`WD_BITE` sequence within a few dozen cycles each.

// File: rtl/ostmr_pkg.sv
package ostmr_pkg;

    localparam logic [7:0] OFS_CNT = 8'h10;
    localparam logic [7:0] OFS_STS = 8'h14;
    localparam logic [7:0] OFS_WDE = 8'h18;
    localparam logic [7:0] OFS_IEN = 8'h1C;

    typedef enum logic [1:0] {
        WD_OFF   = 2'd0,
        WD_ARMED = 2'd1,
        WD_BITE  = 2'd2
    } wd_state_e;

endpackage

// File: rtl/ostmr_counter.sv
module ostmr_counter #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_en,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt,
    output logic [W-1:0] cnt_inc,
    output logic         step
);

    assign cnt_inc = cnt + W'(1);
    assign step    = tick_en & ~load_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt <= '0;
        else if (load_en) cnt <= load_val;
        else if (step)    cnt <= cnt_inc;
    end

endmodule

// File: rtl/ostmr_match_ch.sv
module ostmr_match_ch #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] cnt_inc,
    input  logic         step,
    output logic [W-1:0] match_q,
    output logic         hit
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     match_q <= '0;
        else if (wr_en) match_q <= wdata;
    end

    // Event only when an increment lands on the match value.
    assign hit = step && (cnt_inc == match_q);

endmodule

// File: rtl/ostmr_wdog.sv
module ostmr_wdog #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    input  logic         hit,
    output logic [W-1:0] wd_q,
    output logic         rst_req
);
    import ostmr_pkg::*;

    wd_state_e state, state_nxt;
    logic      bite;

    assign bite = (state == WD_ARMED) && hit;

    always_comb begin
        state_nxt = state;
        unique case (state)
            WD_OFF:   if (wr_en && wdata[0]) state_nxt = WD_ARMED;
            WD_ARMED: begin
                if (hit)                    state_nxt = WD_BITE;
                else if (wr_en && !wdata[0]) state_nxt = WD_OFF;
            end
            WD_BITE:  state_nxt = (wr_en && wdata[0]) ? WD_ARMED : WD_OFF;
            default:  state_nxt = WD_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= WD_OFF;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     wd_q <= '0;
        else if (bite)  wd_q <= '0;
        else if (wr_en) wd_q <= wdata;
    end

    always_comb begin
        rst_req = (state == WD_BITE);
    end

endmodule

// File: rtl/os_tick_timer.sv
module os_tick_timer #(
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned IE_W   = 12,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [CNT_W-1:0]  rd_data,
    output logic              rd_err,
    output logic [NUM_CH-1:0] irq,
    output logic              rst_req
);
    import ostmr_pkg::*;

    localparam int unsigned      WD_CH = NUM_CH - 1;
    localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(OFS_CNT);
    localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(OFS_STS);
    localparam logic [ADDR_W-1:0] A_WDE = ADDR_W'(OFS_WDE);
    localparam logic [ADDR_W-1:0] A_IEN = ADDR_W'(OFS_IEN);

    logic [CNT_W-1:0]  cnt, cnt_inc;
    logic              step;
    logic [CNT_W-1:0]  match_q [NUM_CH];
    logic [NUM_CH-1:0] hit, m_sel;
    logic [NUM_CH-1:0] sts_q;
    logic [IE_W-1:0]   ie_q;
    logic [CNT_W-1:0]  wd_q;
    logic [CNT_W-1:0]  rd_mux;
    logic              rd_miss;

    // Match register n decodes at byte offset 4*n.
    always_comb begin
        for (int n = 0; n < NUM_CH; n++)
            m_sel[n] = (addr == ADDR_W'(4 * n));
    end

    ostmr_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .load_en(wr_en && addr == A_CNT), .load_val(wdata),
        .cnt(cnt), .cnt_inc(cnt_inc), .step(step)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        ostmr_match_ch #(.W(CNT_W)) u_ch (
            .clk(clk), .rst_n(rst_n),
            .wr_en(wr_en && m_sel[g]), .wdata(wdata),
            .cnt_inc(cnt_inc), .step(step),
            .match_q(match_q[g]), .hit(hit[g])
        );
    end

    ostmr_wdog #(.W(CNT_W)) u_wd (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en && addr == A_WDE), .wdata(wdata),
        .hit(hit[WD_CH]), .wd_q(wd_q), .rst_req(rst_req)
    );

    // Status: a fresh event wins over a same-cycle clear.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sts_q <= '0;
            ie_q  <= '0;
        end else begin
            sts_q <= (sts_q & ~((wr_en && addr == A_STS) ? wdata[NUM_CH-1:0] : '0))
                   | (hit & ie_q[NUM_CH-1:0]);
            if (wr_en && addr == A_IEN) ie_q <= wdata[IE_W-1:0];
        end
    end

    assign irq = sts_q;

    always_comb begin
        rd_mux  = '0;
        rd_miss = 1'b0;
        if      (addr == A_CNT) rd_mux = cnt;
        else if (addr == A_STS) rd_mux = CNT_W'(sts_q);
        else if (addr == A_WDE) rd_mux = wd_q;
        else if (addr == A_IEN) rd_mux = CNT_W'(ie_q);
        else if (|m_sel) begin
            for (int n = 0; n < NUM_CH; n++)
                if (m_sel[n]) rd_mux = match_q[n];
        end else rd_miss = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
            rd_err  <= 1'b0;
        end else begin
            rd_err <= rd_en && rd_miss;
            if (rd_en) rd_data <= rd_mux;
        end
    end

endmodule

// File: rtl/ostmr_chk.sv
module ostmr_chk #(
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned IE_W   = 12,
    parameter int unsigned ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic [ADDR_W-1:0] addr,
    input logic [CNT_W-1:0]  wdata,
    input logic              wr_en,
    input logic              rd_en,
    input logic              rd_err,
    input logic [NUM_CH-1:0] irq,
    input logic              rst_req,
    input logic [CNT_W-1:0]  cnt,
    input logic [IE_W-1:0]   ie_q,
    input logic [CNT_W-1:0]  wd_q
);
    localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(8'h10);
    localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(8'h14);

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !(wr_en && addr == A_CNT)) |=> cnt == $past(cnt) + CNT_W'(1));

    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !(wr_en && addr == A_CNT)) |=> $stable(cnt));

    // R9
    rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R9
    wd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> !wd_q[0]);

    // R12
    rd_err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |-> $past(rd_en));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch_chk
        // R7
        irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == A_STS && wdata[g] && !tick_en) |=> !irq[g]);
        // R4
        irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq[g]) |-> $past(tick_en));
        // R5
        dis_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!irq[g] && !ie_q[g]) |=> !irq[g]);
    end

endmodule

bind os_tick_timer ostmr_chk #(
    .CNT_W(CNT_W), .NUM_CH(NUM_CH), .IE_W(IE_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .addr(addr),
    .wdata(wdata), .wr_en(wr_en), .rd_en(rd_en), .rd_err(rd_err),
    .irq(irq), .rst_req(rst_req), .cnt(cnt), .ie_q(ie_q), .wd_q(wd_q)
);

// File: tb/sim_os_tick_timer.sv
module sim_os_tick_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        rd_err;
    logic [3:0]  irq;
    logic        rst_req;

    int n_chk = 0;
    int n_bad = 0;
    int rst_pulses = 0;

    always #2.5 clk = ~clk;

    os_tick_timer u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .addr(addr),
        .wdata(wdata), .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data),
        .rd_err(rd_err), .irq(irq), .rst_req(rst_req)
    );

    always @(negedge clk) if (rst_n && rst_req) rst_pulses++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic e);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data; e = rd_err;
    endtask

    task automatic tick(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic rchk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d; logic e;
        rd(a, d, e);
        chk(req, d, exp);
    endtask

    task automatic t_reset();
        for (int i = 0; i < 8; i++) rchk("R1", 8'(i * 4), 32'h0);
        chk("R1 irq", 32'(irq), 32'h0);
        chk("R1 rst_req", 32'(rst_req), 32'h0);
    endtask

    task automatic t_map();
        wr(8'h00, 32'h1111_1111); wr(8'h04, 32'h2222_2222);
        wr(8'h08, 32'h3333_3333); wr(8'h0C, 32'h4444_4444);
        rchk("R13 m0", 8'h00, 32'h1111_1111); rchk("R13 m1", 8'h04, 32'h2222_2222);
        rchk("R13 m2", 8'h08, 32'h3333_3333); rchk("R13 m3", 8'h0C, 32'h4444_4444);
        wr(8'h1C, 32'hFFFF_FFF0);
        rchk("R8 ie mask", 8'h1C, 32'h0000_0FF0);
        wr(8'h1C, 32'h0);
    endtask

    task automatic t_count();
        wr(8'h10, 32'd100);
        rchk("R3 load", 8'h10, 32'd100);
        tick(5);
        rchk("R2 advance", 8'h10, 32'd105);
        repeat (4) @(negedge clk);
        rchk("R2 hold", 8'h10, 32'd105);
        // load with tick held high: load wins
        @(negedge clk);
        tick_en = 1'b1; addr = 8'h10; wdata = 32'd40; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick_en = 1'b0;
        rchk("R3 load over tick", 8'h10, 32'd40);
    endtask

    task automatic t_match();
        wr(8'h1C, 32'h1);
        wr(8'h00, 32'd110);
        wr(8'h10, 32'd100);
        tick(9);
        chk("R4 before", 32'(irq[0]), 32'h0);
        tick(1);
        chk("R4 irq same cycle", 32'(irq[0]), 32'h1);
        tick(3);
        chk("R4 sticky", 32'(irq[0]), 32'h1);
        rchk("R4 status", 8'h14, 32'h1);
    endtask

    task automatic t_clear();
        wr(8'h14, 32'h2);
        rchk("R7 unwritten kept", 8'h14, 32'h1);
        chk("R7 irq kept", 32'(irq[0]), 32'h1);
        wr(8'h14, 32'h1);
        chk("R7 irq dropped", 32'(irq[0]), 32'h0);
        rchk("R7 status cleared", 8'h14, 32'h0);
    endtask

    task automatic t_disabled();
        wr(8'h04, 32'd503);
        wr(8'h10, 32'd500);
        tick(4);
        chk("R5 irq1 quiet", 32'(irq), 32'h0);
        rchk("R5 status quiet", 8'h14, 32'h0);
    endtask

    task automatic t_equal();
        wr(8'h00, 32'd200);
        wr(8'h10, 32'd200);
        repeat (3) @(negedge clk);
        chk("R6 load onto match", 32'(irq[0]), 32'h0);
        tick(1);
        chk("R6 move past", 32'(irq[0]), 32'h0);
        rchk("R6 status", 8'h14, 32'h0);
    endtask

    task automatic t_wrap();
        wr(8'h1C, 32'h4);
        wr(8'h08, 32'd1);
        wr(8'h10, 32'hFFFF_FFFE);
        tick(2);
        chk("R11 not before wrap", 32'(irq[2]), 32'h0);
        rchk("R2 wrap to zero", 8'h10, 32'h0);
        tick(1);
        chk("R11 fires after wrap", 32'(irq[2]), 32'h1);
        wr(8'h14, 32'hF);
        wr(8'h1C, 32'h0);
    endtask

    task automatic t_wdog();
        chk("R9 no pulse yet", 32'(rst_pulses), 32'd0);
        wr(8'h0C, 32'd300);
        wr(8'h10, 32'd295);
        wr(8'h18, 32'h1);
        tick(4);
        chk("R9 not early", 32'(rst_req), 32'h0);
        tick(1);
        chk("R9 rst_req high", 32'(rst_req), 32'h1);
        @(negedge clk);
        chk("R9 rst_req one cycle", 32'(rst_req), 32'h0);
        chk("R9 pulse count", 32'(rst_pulses), 32'd1);
        chk("R9 irq3 disabled", 32'(irq[3]), 32'h0);
        rchk("R9 wd cleared", 8'h18, 32'h0);
    endtask

    task automatic t_wdog_off();
        wr(8'h18, 32'h2);
        wr(8'h10, 32'd295);
        tick(5);
        @(negedge clk);
        chk("R10 no pulse", 32'(rst_pulses), 32'd1);
        rchk("R10 wd kept", 8'h18, 32'h2);
    endtask

    task automatic t_unmapped();
        logic [31:0] d; logic e;
        wr(8'h1C, 32'h5);
        wr(8'h10, 32'd77);
        rd(8'h24, d, e);
        chk("R12 unmapped data", d, 32'h0);
        chk("R12 unmapped err", 32'(e), 32'h1);
        rd(8'h03, d, e);
        chk("R12 unaligned err", 32'(e), 32'h1);
        wr(8'h20, 32'hDEAD_BEEF);
        wr(8'h11, 32'hDEAD_BEEF);
        rd(8'h1C, d, e);
        chk("R12 ie untouched", d, 32'h5);
        chk("R12 mapped err low", 32'(e), 32'h0);
        rchk("R12 counter untouched", 8'h10, 32'd77);
        rchk("R12 wd untouched", 8'h18, 32'h2);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_map();
        t_count();
        t_match();
        t_clear();
        t_disabled();
        t_equal();
        t_wrap();
        t_wdog();
        t_wdog_off();
        t_unmapped();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog run did not finish actual=hung expected=done");
        finish_run();
    end

endmodule